// File: doc/BRIEF.md
# Direct-Store Segment Access Checker

This block decides the outcome of a memory access that falls in a segment marked for direct-store (I/O controller) use. For each request it takes the segment register, the effective address, the access kind, the privilege state and the instruction class. One clock later it returns exactly one of three results:

- a grant, with a real address and a permission set;
- a fault, with a fault type and a 32-bit status word;
- an illegal-request flag, when the class or kind code is not recognised.

Data-side faults also capture the effective address in a fault-address register. That register holds its value until the next data-side fault.

The block sits after the segment lookup of an address translation unit. Only accesses whose segment has the direct-store flag set are routed to it. It does not issue any I/O bus traffic and does not touch page tables.

Top module: `ds_seg_checker`

## Requirements
- R1: The protection key is segment bit 29 when `priv_user` is 1, and segment bit 30 when `priv_user` is 0.
- R2: When segment bits 28..20 equal 9'h07F, the access is granted whatever its kind, class or key. Permissions are `perm` = 3'b111 ({exec, write, read}), and the real address is {segment bits 3..0, effective address bits 27..0}.
- R3: Outside R2, a fetch (`acc_kind` = 2) always faults.
  - `fault_kind` = 1 (instruction fault).
  - Status is 32'h1000_0000.
  - The class code is not looked at.
- R4: Outside R2 and R3, a float access (`op_class` = 1) faults with `fault_kind` = 3 (alignment) and status 0.
- R5: Outside R2 and R3, a reservation access (`op_class` = 2) raises a data fault (`fault_kind` = 2). The status is 32'h0600_0000 on a write (`acc_kind` = 1) and 32'h0400_0000 on a read (`acc_kind` = 0).
- R6: Outside R2 and R3, a cache-operation access (`op_class` = 4) is granted. The real address equals the effective address and `perm` = 0.
- R7: Outside R2 and R3, an external-control access (`op_class` = 5) raises a data fault with status 32'h0610_0000 on a write and 32'h0410_0000 on a read.
- R8: Outside R2 and R3, an integer access (`op_class` = 0) is handled by key:
  - A read with key 0, or a write with key 1, is granted with real address equal to the effective address, and `perm` = {1'b0, key, ~key}.
  - Any other integer access raises a data fault with status 32'h0A00_0000 on a write and 32'h0800_0000 on a read.
- R9: On every response with `fault_kind` 2 or 3, `fault_addr` loads the effective address in the same edge that presents the response. Otherwise `fault_addr` holds its value.
- R10: Outside R2 and R3, a class code of 3, 6 or 7, or an `acc_kind` of 3, sets `illegal`. Grant and fault both stay 0, and `fault_addr` is unchanged.
- R11: `rsp_vld` pulses high for exactly the cycle after a `req_vld` cycle. At most one of `grant`, `fault` and `illegal` is 1.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_vld | input | 1 | request present this cycle |
| seg_reg | input | 32 | segment register value |
| eff_addr | input | 32 | effective address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| priv_user | input | 1 | 1 = user state |
| op_class | input | 3 | 0 int, 1 float, 2 reservation, 4 cache op, 5 external control |
| rsp_vld | output | 1 | result valid |
| grant | output | 1 | access granted |
| real_addr | output | 32 | granted real address |
| perm | output | 3 | {exec, write, read} on grant |
| fault | output | 1 | access faulted |
| fault_kind | output | 2 | 1 instruction, 2 data, 3 alignment |
| fault_status | output | 32 | fault status word |
| illegal | output | 1 | unrecognised request |
| fault_addr | output | 32 | last data-side faulting address |

## Verification
Two functions can fall on the same request, and in each case the bench checks that the right one wins:

- **Escape against rejection.** The bus-unit escape of R2 can coincide with a fetch, or with a rejecting class. Random segment values force the 9'h07F field on about a quarter of requests, and directed cases pair it with a fetch and with an illegal code. Each result must be a full-permission grant, with `fault_addr` left untouched.
- **Response and address capture.** The response and the fault-address capture share one edge. Every data or alignment fault is checked by reading `fault_addr` in the same sample as the response. Back-to-back faults must show the newest address.

// File: rtl/ds_seg_checker.sv
module ds_seg_checker #(
  parameter int AW = 32,
  parameter logic [8:0] ESC_ID = 9'h07F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [31:0]   seg_reg,
  input  logic [AW-1:0] eff_addr,
  input  logic [1:0]    acc_kind,
  input  logic          priv_user,
  input  logic [2:0]    op_class,
  output logic          rsp_vld,
  output logic          grant,
  output logic [AW-1:0] real_addr,
  output logic [2:0]    perm,
  output logic          fault,
  output logic [1:0]    fault_kind,
  output logic [31:0]   fault_status,
  output logic          illegal,
  output logic [AW-1:0] fault_addr
);
  localparam int LOW = AW - 4;

  logic key, escape, is_wr, is_fetch;
  logic n_grant, n_fault, n_illegal;
  logic [1:0] n_fkind;
  logic [31:0] n_status;
  logic [AW-1:0] n_raddr;
  logic [2:0] n_perm;

  assign key      = priv_user ? seg_reg[29] : seg_reg[30];
  assign escape   = (seg_reg[28:20] == ESC_ID);
  assign is_wr    = (acc_kind == 2'd1);
  assign is_fetch = (acc_kind == 2'd2);

  always_comb begin
    n_grant = 1'b0; n_fault = 1'b0; n_illegal = 1'b0;
    n_fkind = 2'd0; n_status = 32'h0; n_raddr = '0; n_perm = 3'b000;
    if (escape) begin
      n_grant = 1'b1;
      n_perm  = 3'b111;
      n_raddr = {seg_reg[3:0], eff_addr[LOW-1:0]};
    end else if (is_fetch) begin
      n_fault = 1'b1; n_fkind = 2'd1; n_status = 32'h1000_0000;
    end else if (acc_kind == 2'd3) begin
      n_illegal = 1'b1;
    end else begin
      case (op_class)
        3'd0: if (is_wr ? key : !key) begin
                n_grant = 1'b1; n_raddr = eff_addr; n_perm = {1'b0, key, ~key};
              end else begin
                n_fault = 1'b1; n_fkind = 2'd2;
                n_status = is_wr ? 32'h0A00_0000 : 32'h0800_0000;
              end
        3'd1: begin n_fault = 1'b1; n_fkind = 2'd3; end
        3'd2: begin
                n_fault = 1'b1; n_fkind = 2'd2;
                n_status = is_wr ? 32'h0600_0000 : 32'h0400_0000;
              end
        3'd4: begin n_grant = 1'b1; n_raddr = eff_addr; end
        3'd5: begin
                n_fault = 1'b1; n_fkind = 2'd2;
                n_status = is_wr ? 32'h0610_0000 : 32'h0410_0000;
              end
        default: n_illegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0; grant <= 1'b0; fault <= 1'b0; illegal <= 1'b0;
      fault_kind <= 2'd0; fault_status <= 32'h0; real_addr <= '0;
      perm <= 3'b000; fault_addr <= '0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        grant <= n_grant; fault <= n_fault; illegal <= n_illegal;
        fault_kind <= n_fkind; fault_status <= n_status;
        real_addr <= n_raddr; perm <= n_perm;
        if (n_fkind[1]) fault_addr <= eff_addr;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, fault, illegal}));                                   // R11
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);                                                 // R11
  AST_FETCH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && fault && fault_kind == 2'd1) |-> fault_status == 32'h1000_0000); // R3
  AST_FADDR_ONLY_ON_DFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> (rsp_vld && fault && fault_kind[1]));        // R9
  AST_FULL_PERM_IS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (perm == 3'b111) |-> grant);                                          // R2
  AST_ALIGN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_kind == 2'd3) |-> fault_status == 32'h0);             // R4
endmodule

// File: tb/test_ds_seg_checker.sv
module test_ds_seg_checker;
  logic clk = 1'b0, rst_n = 1'b0, req_vld = 1'b0, priv_user = 1'b0;
  logic [31:0] seg_reg = '0, eff_addr = '0;
  logic [1:0] acc_kind = '0;
  logic [2:0] op_class = '0;
  logic rsp_vld, grant, fault, illegal;
  logic [31:0] real_addr, fault_status, fault_addr;
  logic [2:0] perm;
  logic [1:0] fault_kind;
  int total = 0, bad = 0, cycles = 0;
  logic [31:0] exp_fa = '0;

  always #2.5 clk = ~clk;

  ds_seg_checker i_ds_seg_checker (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .seg_reg(seg_reg),
    .eff_addr(eff_addr), .acc_kind(acc_kind), .priv_user(priv_user),
    .op_class(op_class), .rsp_vld(rsp_vld), .grant(grant),
    .real_addr(real_addr), .perm(perm), .fault(fault),
    .fault_kind(fault_kind), .fault_status(fault_status),
    .illegal(illegal), .fault_addr(fault_addr));

  // {grant, fault, illegal, fkind, status, raddr, perm}
  function automatic logic [71:0] model(input logic [31:0] s, input logic [31:0] ea,
      input logic [1:0] k, input logic u, input logic [2:0] c, output string tag);
    logic key = u ? s[29] : s[30];
    logic wr = (k == 2'd1);
    tag = "R10";
    if (s[28:20] == 9'h07F) begin tag = "R2"; return {3'b100, 2'd0, 32'h0, s[3:0], ea[27:0], 3'b111}; end
    if (k == 2'd2) begin tag = "R3"; return {3'b010, 2'd1, 32'h1000_0000, 32'h0, 3'b000}; end
    if (k == 2'd3) return {3'b001, 2'd0, 32'h0, 32'h0, 3'b000};
    case (c)
      3'd0: begin
        tag = "R8";
        if (wr ? key : !key) return {3'b100, 2'd0, 32'h0, ea, 1'b0, key, ~key};
        return {3'b010, 2'd2, (wr ? 32'h0A00_0000 : 32'h0800_0000), 32'h0, 3'b000};
      end
      3'd1: begin tag = "R4"; return {3'b010, 2'd3, 32'h0, 32'h0, 3'b000}; end
      3'd2: begin tag = "R5"; return {3'b010, 2'd2, (wr ? 32'h0600_0000 : 32'h0400_0000), 32'h0, 3'b000}; end
      3'd4: begin tag = "R6"; return {3'b100, 2'd0, 32'h0, ea, 3'b000}; end
      3'd5: begin tag = "R7"; return {3'b010, 2'd2, (wr ? 32'h0610_0000 : 32'h0410_0000), 32'h0, 3'b000}; end
      default: return {3'b001, 2'd0, 32'h0, 32'h0, 3'b000};
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] s, input logic [31:0] ea, input logic [1:0] k,
                       input logic u, input logic [2:0] c);
    string tag;
    logic [71:0] e;
    @(negedge clk);
    seg_reg = s; eff_addr = ea; acc_kind = k; priv_user = u; op_class = c; req_vld = 1'b1;
    e = model(s, ea, k, u, c, tag);
    if (e[68]) exp_fa = ea;
    @(negedge clk);
    req_vld = 1'b0;
    check("R11", {127'h0, rsp_vld}, 128'h1);
    check(tag, {56'h0, grant, fault, illegal, fault_kind, fault_status, real_addr, perm},
          {56'h0, e});
    check("R9", {96'h0, fault_addr}, {96'h0, exp_fa});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R12", {56'h0, rsp_vld, grant, fault, illegal, fault_kind, fault_status, real_addr, perm},
          72'h0);
    check("R12", {96'h0, fault_addr}, 128'h0);
    rst_n = 1'b1;
    // R1: key bit choice by privilege
    issue(32'h2000_0000, 32'h1234_5678, 2'd0, 1'b1, 3'd0); // user, key1: read faults
    issue(32'h2000_0000, 32'h1234_5000, 2'd0, 1'b0, 3'd0); // super, key0: read grant
    issue(32'h4000_0000, 32'hAAAA_0000, 2'd1, 1'b0, 3'd0); // super key1: write grant
    issue(32'h4000_0000, 32'hBBBB_0000, 2'd1, 1'b1, 3'd0); // user key0: write faults
    // R2 escape wins over fetch and illegal code
    issue(32'h07F0_000C, 32'hF123_4567, 2'd2, 1'b1, 3'd1);
    issue(32'h07F0_0003, 32'h0000_0010, 2'd0, 1'b0, 3'd7);
    // R3 fetch ignores class
    issue(32'h0000_0000, 32'h1111_0000, 2'd2, 1'b0, 3'd4);
    // R4/R5/R7/R6/R10 and back-to-back faults for R9
    issue(32'h0, 32'hC000_0001, 2'd1, 1'b0, 3'd1);
    issue(32'h0, 32'hC000_0002, 2'd1, 1'b0, 3'd2);
    issue(32'h0, 32'hC000_0003, 2'd0, 1'b0, 3'd5);
    issue(32'h0, 32'hC000_0004, 2'd0, 1'b0, 3'd4);
    issue(32'h0, 32'hC000_0005, 2'd0, 1'b0, 3'd6);
    issue(32'h0, 32'hC000_0006, 2'd3, 1'b0, 3'd0);
    @(negedge clk);
    check("R11", {127'h0, rsp_vld}, 128'h0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] s = $urandom;
      if ($urandom_range(3) == 0) s[28:20] = 9'h07F;
      issue(s, $urandom, 2'($urandom_range(3)), 1'($urandom_range(1)), 3'($urandom_range(7)));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule